// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block walks the column addresses of one SDRAM burst inside an already open row. A one-cycle start pulse captures a start column, a burst-length code and an ordering choice. From the next clock on, the block presents one column address per cycle with a valid flag. A last flag marks the closing beat of a finite burst. Finite bursts of 1, 2, 4 or 8 beats use either linear or interleaved ordering. A full-page burst sweeps the whole row with wrap-around and keeps going until a terminate input stops it.

The controller around the block issues the commands, moves the data and keeps the bank timing. It uses the address stream to drive the column field of each beat. The design is a three-state machine:

- `ST_IDLE`: no burst is running.
- `ST_BURST`: a finite burst is running.
- `ST_PAGE`: a full-page burst is running.

The transitions are:

- IDLE to BURST: start with a finite length code.
- IDLE to PAGE: start with the full-page code.
- BURST to BURST: the beat advances (no terminate, and the beat is not the final one).
- BURST to IDLE: the final beat has been presented, or terminate was seen.
- PAGE to PAGE: the beat advances and wraps.
- PAGE to IDLE: terminate was seen.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset `col_valid` and `col_last` are 0.
- R2: A `start` pulse seen at a clock edge while idle makes `col_valid` 1 after that edge, with `col_out` equal to the captured `start_col` (beat 0). A `term` at the same edge does not block it.
- R3: A finite burst presents exactly BL consecutive valid beats, one per clock, and then `col_valid` drops to 0.
- R4: `bl_sel` codes 3'b000, 3'b001, 3'b010 and 3'b011 select BL = 1, 2, 4 and 8. With `burst_ilv` = 0 (sequential), beat k has its low log2(BL) bits equal to (start + k) mod BL, and all higher bits equal to the start column.
- R5: With `burst_ilv` = 1 (interleave) and a finite length, beat k has its low log2(BL) bits equal to the start low bits XOR k, and all higher bits equal to the start column.
- R6: `bl_sel[2]` = 1 selects full page. Beat k is (start + k) mod 256, wrapping from 255 to 0. `burst_ilv` is ignored. The burst keeps running beyond 256 beats until it is terminated.
- R7: `col_last` is 1 exactly on beat BL-1 of a finite burst, and never during a full-page burst.
- R8: A `term` seen at a clock edge while a beat is valid ends the burst, so `col_valid` is 0 after that edge. A `term` while idle has no effect.
- R9: A `start` pulse, or any change of `start_col`, `bl_sel` or `burst_ilv`, during a running burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst start pulse, honoured when idle |
| start_col | input | 8 | First column of the burst |
| bl_sel | input | 3 | Burst length code (see R4, R6) |
| burst_ilv | input | 1 | 0 = sequential, 1 = interleave order |
| term | input | 1 | Ends a running burst |
| col_out | output | 8 | Column address of the current beat |
| col_valid | output | 1 | `col_out` holds a beat |
| col_last | output | 1 | Current beat is the final one of a finite burst |

## Verification
The assertions assume that `start` and `term` are synchronous to `clk` and free of X after reset. The bench drives them at falling edges, so each one is stable across the rising edge that samples it. The page-increment property assumes that the configuration captured at start is not disturbed mid-burst. The stimulus deliberately toggles the configuration inputs during a burst to show that they are ignored. The bench always asserts `term` for a full-page burst eventually, because that burst never ends on its own.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_t;

    localparam int unsigned BL_CODE_W = 3;

endpackage

// File: rtl/col_seq_fsm.sv
module col_seq_fsm
    import col_seq_pkg::*;
#(
    parameter int unsigned COL_W  = 8,
    parameter int unsigned CODE_W = BL_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              term,
    input  logic [COL_W-1:0]  start_col,
    input  logic [CODE_W-1:0] bl_code,
    input  logic              ilv_in,
    output logic [COL_W-1:0]  base_q,
    output logic [COL_W-1:0]  beat_q,
    output logic [COL_W-1:0]  mask_q,
    output logic              ilv_q,
    output logic              beat_valid,
    output logic              beat_last,
    output logic              page_mode
);

    localparam int unsigned LEN_W = CODE_W - 1;

    seq_state_t       state_q, state_d;
    logic [COL_W-1:0] beat_d;
    logic [COL_W-1:0] mask_d;
    logic             page_in;
    logic             load;

    assign page_in = bl_code[CODE_W-1];

    // Low-bit mask of the requested burst: BL-1, or all ones for full page
    always_comb begin
        mask_d = '0;
        for (int i = 0; i < int'(COL_W); i++) begin
            if (page_in || (i < int'(bl_code[LEN_W-1:0])))
                mask_d[i] = 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    beat_d  = '0;
                    state_d = page_in ? ST_PAGE : ST_BURST;
                end
            end
            ST_BURST: begin
                if (term || (beat_q == mask_q))
                    state_d = ST_IDLE;
                else
                    beat_d = beat_q + COL_W'(1);
            end
            ST_PAGE: begin
                if (term)
                    state_d = ST_IDLE;
                else
                    beat_d = beat_q + COL_W'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with captured burst configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            if (load) begin
                base_q <= start_col;
                mask_q <= mask_d;
                ilv_q  <= ilv_in & ~page_in;
            end
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        beat_valid = 1'b0;
        beat_last  = 1'b0;
        page_mode  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BURST: begin
                beat_valid = 1'b1;
                beat_last  = (beat_q == mask_q);
            end
            ST_PAGE: begin
                beat_valid = 1'b1;
                page_mode  = 1'b1;
            end
            default: ;
        endcase
    end

    // R9: captured configuration holds while a burst runs
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(base_q) && $stable(mask_q) && $stable(ilv_q)));

    // R6: a full-page burst leaves only on terminate
    a_r6_page_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && !term) |=> (state_q == ST_PAGE));

endmodule

// File: rtl/col_seq_addr.sv
module col_seq_addr #(
    parameter int unsigned COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] xor_mix;

    assign lin_sum = base + beat;
    assign xor_mix = base ^ beat;

    // Per bit: masked bits follow the chosen ordering, the rest stay at base
    for (genvar g = 0; g < int'(COL_W); g++) begin : g_bit
        assign col[g] = mask[g] ? (ilv ? xor_mix[g] : lin_sum[g]) : base[g];
    end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import col_seq_pkg::*;
#(
    parameter int unsigned COL_W  = 8,
    parameter int unsigned CODE_W = BL_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [CODE_W-1:0] bl_sel,
    input  logic              burst_ilv,
    input  logic              term,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last
);

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             page_mode;

    col_seq_fsm #(.COL_W(COL_W), .CODE_W(CODE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .term       (term),
        .start_col  (start_col),
        .bl_code    (bl_sel),
        .ilv_in     (burst_ilv),
        .base_q     (base_q),
        .beat_q     (beat_q),
        .mask_q     (mask_q),
        .ilv_q      (ilv_q),
        .beat_valid (col_valid),
        .beat_last  (col_last),
        .page_mode  (page_mode)
    );

    col_seq_addr #(.COL_W(COL_W)) u_addr (
        .base (base_q),
        .beat (beat_q),
        .mask (mask_q),
        .ilv  (ilv_q),
        .col  (col_out)
    );

    // R7: last marks a valid beat only
    a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R3: a final beat is followed by an idle cycle
    a_r3_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !term) |=> !col_valid);

    // R3: a non-final beat is followed by another beat
    a_r3_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !term) |=> col_valid);

    // R8: terminate stops the stream
    a_r8_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && term) |=> !col_valid);

    // R2: start while idle yields a beat next cycle
    a_r2_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_valid && start) |=> col_valid);

    // R6: full-page beats advance by one with wrap
    a_r6_page_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (page_mode && !term) |=> (col_out == COL_W'($past(col_out) + COL_W'(1))));

    // R7: no last flag in full-page mode
    a_r7_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        page_mode |-> !col_last);

endmodule

// File: tb/tb_sdram_col_seq.sv
module tb_sdram_col_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] bl_sel = '0;
    logic       burst_ilv = 1'b0;
    logic       term = 1'b0;
    logic [7:0] col_out;
    logic       col_valid;
    logic       col_last;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_col_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .bl_sel    (bl_sel),
        .burst_ilv (burst_ilv),
        .term      (term),
        .col_out   (col_out),
        .col_valid (col_valid),
        .col_last  (col_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected column for beat k, from the requirements
    function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                           input logic ilv, input int k);
        logic [7:0] m;
        logic [7:0] kk;
        kk = 8'(k);
        if (code[2]) return 8'(s + kk);
        m = 8'((1 << code[1:0]) - 1);
        if (ilv) return (s & ~m) | ((s ^ kk) & m);
        return (s & ~m) | (8'(s + kk) & m);
    endfunction

    function automatic string tag_for(input logic [2:0] code, input logic ilv);
        if (code[2]) return "R6";
        if (ilv) return "R5";
        return "R4";
    endfunction

    // Start a burst: drive at a falling edge, sample beat 0 at the next one
    task automatic launch(input logic [7:0] s, input logic [2:0] code, input logic ilv);
        start_col = s; bl_sel = code; burst_ilv = ilv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk(col_valid == 1'b0, "R1 valid", int'(col_valid), 0);
        chk(col_last == 1'b0, "R1 last", int'(col_last), 0);
    endtask

    // Full finite burst with per-beat checks; optional mid-burst disturbance
    task automatic t_finite(input logic [7:0] s, input logic [2:0] code, input logic ilv,
                            input bit disturb);
        int bl;
        string tg;
        bl = 1 << code[1:0];
        tg = tag_for(code, ilv);
        launch(s, code, ilv);
        chk(col_valid && col_out == s, "R2 beat0", int'(col_out), int'(s));
        for (int k = 0; k < bl; k++) begin
            chk(col_valid == 1'b1, "R3 valid", int'(col_valid), 1);
            chk(col_out == exp_col(s, code, ilv, k), tg, int'(col_out),
                int'(exp_col(s, code, ilv, k)));
            chk(col_last == (k == bl - 1), "R7 last", int'(col_last), int'(k == bl - 1));
            if (disturb) begin
                // R9: new start and config while busy
                start = 1'b1; start_col = ~s; bl_sel = 3'b100; burst_ilv = ~ilv;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(col_valid == 1'b0, "R3 end", int'(col_valid), 0);
    endtask

    task automatic t_disturb();
        t_finite(8'h3D, 3'b011, 1'b0, 1'b1);  // R9
        chk(col_valid == 1'b0, "R9 no restart", int'(col_valid), 0);
    endtask

    task automatic t_page(input logic [7:0] s, input logic ilv, input int beats);
        launch(s, 3'b100, ilv);
        for (int k = 0; k < beats; k++) begin
            chk(col_valid && col_out == exp_col(s, 3'b100, ilv, k), "R6 page col",
                int'(col_out), int'(exp_col(s, 3'b100, ilv, k)));
            chk(col_last == 1'b0, "R7 page no last", int'(col_last), 0);
            if (k == beats - 1) term = 1'b1;
            @(negedge clk);
            term = 1'b0;
        end
        chk(col_valid == 1'b0, "R8 page term", int'(col_valid), 0);
    endtask

    task automatic t_term_mid();
        launch(8'h50, 3'b011, 1'b1);
        for (int k = 0; k < 4; k++) begin
            chk(col_out == exp_col(8'h50, 3'b011, 1'b1, k), "R5 pre-term",
                int'(col_out), int'(exp_col(8'h50, 3'b011, 1'b1, k)));
            if (k == 3) term = 1'b1;
            @(negedge clk);
            term = 1'b0;
        end
        chk(col_valid == 1'b0, "R8 term mid", int'(col_valid), 0);
        @(negedge clk);
        chk(col_valid == 1'b0, "R8 stays idle", int'(col_valid), 0);
    endtask

    task automatic t_term_idle();
        term = 1'b1;
        @(negedge clk);
        chk(col_valid == 1'b0, "R8 idle term", int'(col_valid), 0);
        // start together with term while idle still launches (R2)
        start_col = 8'h21; bl_sel = 3'b001; burst_ilv = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; term = 1'b0;
        chk(col_valid && col_out == 8'h21, "R2 start with term", int'(col_out), 8'h21);
        @(negedge clk);
        chk(col_out == 8'h20 && col_last, "R4 bl2 wrap", int'(col_out), 8'h20);
        @(negedge clk);
        chk(col_valid == 1'b0, "R3 bl2 end", int'(col_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_finite(8'h47, 3'b000, 1'b0, 1'b0);  // R4 BL1
        t_finite(8'h47, 3'b001, 1'b0, 1'b0);  // R4 BL2
        t_finite(8'h47, 3'b010, 1'b0, 1'b0);  // R4 BL4
        t_finite(8'hAE, 3'b011, 1'b0, 1'b0);  // R4 BL8
        t_finite(8'h47, 3'b010, 1'b1, 1'b0);  // R5 BL4
        t_finite(8'hAE, 3'b011, 1'b1, 1'b0);  // R5 BL8
        t_finite(8'hF3, 3'b001, 1'b1, 1'b0);  // R5 BL2
        t_disturb();
        t_term_mid();
        t_term_idle();
        t_page(8'hF0, 1'b1, 300);             // R6 wrap, ilv ignored
        t_page(8'h05, 1'b0, 3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule